// File: doc/BRIEF.md
# Blanking-Triggered Four-Channel DMA Controller

This block is a multi-channel DMA engine that sits between a configuration write port and a memory bus. Each channel is set up with four registers: source address, destination address, word count and control. When software enables a channel, the programmed values are copied into working registers. The channel then waits for its start condition. That condition is either immediate, or the next horizontal or vertical blanking pulse from the display timing logic. An armed channel issues one bus transfer request per step. Each step moves its working addresses by the unit size and counts down.

Transfer requests leave on a valid/ready stream. The request is offered while `xfer_valid` is high, and a step takes place only in a cycle where `xfer_ready` is also high. While `xfer_ready` is low the controller holds the request and its payload. The payload can change in only two cases: a higher-priority channel becomes armed, or a configuration write changes the offering channel. Only one channel steps per cycle, and the lowest-numbered armed channel wins. `cpu_stall` is raised while the offered request belongs to an immediate-start channel. Each channel has a one-cycle completion interrupt pulse.

A repeating channel stays enabled after its count runs out, but it disarms. On its next matching blanking pulse it re-arms with a fresh count. If its destination mode is increment-reload, its destination address is also restored.

Top module: `blank_dma`

## Requirements
- R1: After reset, `xfer_valid`, `cpu_stall`, `irq` and `chan_en` are all low.
- R2: Configuration register selects are 0 source, 1 destination, 2 count and 3 control. The control word bits are: [1:0] destination mode, [3:2] source mode, [4] repeat, [5] 32-bit unit, [7:6] start timing, [8] interrupt enable and [9] enable. A control write that takes the enable from 0 to 1 copies source, destination and count into the working registers. Source, destination and count writes made at other times do not change the working registers until the next such edge.
- R3: Start timing 0 arms the channel on the enable edge. Timing 1 waits for `vblank`, timing 2 waits for `hblank`, and timing 3 never arms.
- R4: Address modes are 0 increment, 1 decrement and 2 fixed. Mode 3 means increment-reload on the destination and plain increment on the source. The step is 4 bytes with the 32-bit bit set and 2 bytes otherwise, wrapping modulo 2^32. `xfer_wide` reflects that bit.
- R5: A programmed count of 0 gives 2^W-1 steps. W is CNT_W for all channels except the last, which uses CNT_W_LAST. Count bits above W are ignored.
- R6: After the final step of a non-repeating channel, its enable bit (`chan_en`) clears in the next cycle. In that same cycle, its `irq` pulses for exactly one cycle if the interrupt enable is set.
- R7: After the final step of a repeating channel, the enable stays set, no interrupt is raised, and the channel disarms. A later matching blanking pulse re-arms it with the count reloaded. The destination is also reloaded when destination mode is 3.
- R8: A blanking pulse arms only a channel that is enabled, not already armed, and whose timing matches the pulse. All other pulses have no effect.
- R9: Among armed channels the lowest index is offered on `xfer_valid`/`xfer_chan`. At most one channel steps per cycle.
- R10: `cpu_stall` is high exactly when a request is offered by a channel with start timing 0.
- R11: A step happens only when `xfer_valid` and `xfer_ready` are both high. With `xfer_ready` low, the request is held unchanged unless a configuration write or blanking pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | $clog2(NCH) | Channel addressed by the write |
| cfg_reg | input | 2 | Register select within the channel |
| cfg_wdata | input | 32 | Write data |
| hblank | input | 1 | Horizontal blanking pulse |
| vblank | input | 1 | Vertical blanking pulse |
| xfer_valid | output | 1 | Transfer request offered |
| xfer_ready | input | 1 | Bus accepts the request |
| xfer_src | output | 32 | Source address of the request |
| xfer_dst | output | 32 | Destination address of the request |
| xfer_wide | output | 1 | 1 for a 32-bit unit, 0 for 16-bit |
| xfer_chan | output | $clog2(NCH) | Channel issuing the request |
| cpu_stall | output | 1 | Processor stall while an immediate channel is offered |
| irq | output | NCH | Per-channel completion pulse |
| chan_en | output | NCH | Programmed enable bit of each channel |

## Verification
The bench builds the block with four channels and shrinks the counts to CNT_W=6 and CNT_W_LAST=8. With these values, the zero-means-maximum count runs to completion in 63 and 255 steps, so both count widths are covered in full. A behavioural model of the four channels runs alongside the block and is compared every cycle. The comparison covers priority between simultaneously armed channels, wrap on decrement through zero, and re-arming of repeating channels on blanking pulses. It also checks held requests under a pseudo-random ready pattern.

// File: rtl/blank_dma_pkg.sv
package blank_dma_pkg;

  typedef enum logic [1:0] {
    ST_NOW = 2'd0,
    ST_VBL = 2'd1,
    ST_HBL = 2'd2,
    ST_SPC = 2'd3
  } start_e;

  typedef enum logic [1:0] {
    AM_INC = 2'd0,
    AM_DEC = 2'd1,
    AM_FIX = 2'd2,
    AM_RLD = 2'd3
  } amode_e;

  typedef struct packed {
    logic   enable;
    logic   irq_en;
    start_e start;
    logic   wide;
    logic   rpt;
    amode_e src_m;
    amode_e dst_m;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // mode 3 steps upward: reload is handled by the channel, not here
  function automatic logic [31:0] next_addr(logic [31:0] a, amode_e m, logic wide);
    logic [31:0] d;
    d = wide ? 32'd4 : 32'd2;
    case (m)
      AM_DEC:  return a - d;
      AM_FIX:  return a;
      default: return a + d;
    endcase
  endfunction

endpackage

// File: rtl/blank_dma_chan.sv
module blank_dma_chan
  import blank_dma_pkg::*;
#(
  parameter int CW = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_reg,
  input  logic [31:0] wr_data,
  input  logic        hblank,
  input  logic        vblank,
  input  logic        step_i,
  output logic        ready_o,
  output logic [31:0] src_o,
  output logic [31:0] dst_o,
  output logic        wide_o,
  output logic        imm_o,
  output logic        en_o,
  output logic        irq_o
);

  localparam logic [CW-1:0] CMAX = '1;

  ctrl_t         ctrl;
  logic [31:0]   src_p, dst_p, src_w, dst_w;
  logic [CW-1:0] cnt_p, cnt_w;
  logic          armed;

  ctrl_t new_ctrl;
  logic  ctrl_wr, en_edge, blank_hit, last;
  logic [CW-1:0] reload;

  assign new_ctrl  = ctrl_t'(wr_data[CTRL_W-1:0]);
  assign ctrl_wr   = wr_en && (wr_reg == 2'd3);
  assign en_edge   = ctrl_wr && new_ctrl.enable && !ctrl.enable;
  assign blank_hit = !armed && ctrl.enable &&
                     ((hblank && ctrl.start == ST_HBL) || (vblank && ctrl.start == ST_VBL));
  assign last      = (cnt_w == CW'(1));
  assign reload    = (cnt_p == '0) ? CMAX : cnt_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      src_p <= '0;
      dst_p <= '0;
      cnt_p <= '0;
      src_w <= '0;
      dst_w <= '0;
      cnt_w <= '0;
      armed <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (wr_en && wr_reg == 2'd0) src_p <= wr_data;
      if (wr_en && wr_reg == 2'd1) dst_p <= wr_data;
      if (wr_en && wr_reg == 2'd2) cnt_p <= wr_data[CW-1:0];
      if (en_edge) begin
        src_w <= src_p;
        dst_w <= dst_p;
        cnt_w <= reload;
        armed <= (new_ctrl.start == ST_NOW);
      end else if (step_i) begin
        src_w <= next_addr(src_w, ctrl.src_m, ctrl.wide);
        dst_w <= next_addr(dst_w, ctrl.dst_m, ctrl.wide);
        cnt_w <= cnt_w - CW'(1);
        if (last) begin
          armed <= 1'b0;
          if (!ctrl.rpt) begin
            ctrl.enable <= 1'b0;
            irq_o       <= ctrl.irq_en;
          end
        end
      end else if (blank_hit) begin
        armed <= 1'b1;
        if (ctrl.rpt) begin
          cnt_w <= reload;
          if (ctrl.dst_m == AM_RLD) dst_w <= dst_p;
        end
      end
      if (ctrl_wr) ctrl <= new_ctrl;
    end
  end

  assign ready_o = armed && ctrl.enable;
  assign src_o   = src_w;
  assign dst_o   = dst_w;
  assign wide_o  = ctrl.wide;
  assign imm_o   = (ctrl.start == ST_NOW);
  assign en_o    = ctrl.enable;

  // R6
  irq_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(step_i));

  // R3
  arm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(ctrl_wr || hblank || vblank));

  // R4
  fixed_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !ctrl_wr && ctrl.src_m == AM_FIX) |=> $stable(src_w));

endmodule

// File: rtl/blank_dma_pick.sv
module blank_dma_pick #(
  parameter int N  = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);

  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IW'(i);
      end
    end
  end

  assign any = |req;

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any == (grant != '0)));

endmodule

// File: rtl/blank_dma.sv
module blank_dma
  import blank_dma_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int CNT_W      = 14,
  parameter int CNT_W_LAST = 16,
  localparam int IW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_chan,
  input  logic [1:0]      cfg_reg,
  input  logic [31:0]     cfg_wdata,
  input  logic            hblank,
  input  logic            vblank,
  output logic            xfer_valid,
  input  logic            xfer_ready,
  output logic [31:0]     xfer_src,
  output logic [31:0]     xfer_dst,
  output logic            xfer_wide,
  output logic [IW-1:0]   xfer_chan,
  output logic            cpu_stall,
  output logic [NCH-1:0]  irq,
  output logic [NCH-1:0]  chan_en
);

  logic [NCH-1:0] rdy, grant, wide_v, imm_v;
  logic [31:0]    src_v [NCH];
  logic [31:0]    dst_v [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int CW = (g == NCH - 1) ? CNT_W_LAST : CNT_W;
    blank_dma_chan #(.CW(CW)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we && (cfg_chan == IW'(g))),
      .wr_reg  (cfg_reg),
      .wr_data (cfg_wdata),
      .hblank  (hblank),
      .vblank  (vblank),
      .step_i  (grant[g] && xfer_ready),
      .ready_o (rdy[g]),
      .src_o   (src_v[g]),
      .dst_o   (dst_v[g]),
      .wide_o  (wide_v[g]),
      .imm_o   (imm_v[g]),
      .en_o    (chan_en[g]),
      .irq_o   (irq[g])
    );
  end

  blank_dma_pick #(.N(NCH)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (rdy),
    .grant (grant),
    .idx   (xfer_chan),
    .any   (xfer_valid)
  );

  always_comb begin
    xfer_src  = '0;
    xfer_dst  = '0;
    xfer_wide = 1'b0;
    cpu_stall = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (grant[i]) begin
        xfer_src  = src_v[i];
        xfer_dst  = dst_v[i];
        xfer_wide = wide_v[i];
        cpu_stall = imm_v[i];
      end
    end
  end

  // R10
  stall_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> xfer_valid);

  // R11
  held_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready && !cfg_we && !hblank && !vblank)
      |=> (xfer_valid && $stable(xfer_chan) && $stable(xfer_src) && $stable(xfer_dst)));

endmodule

// File: tb/blank_dma_test.sv
module blank_dma_test;
  localparam int    NCH  = 4;
  localparam int    CWL  = 6;
  localparam int    CWH  = 8;
  localparam time   TCLK = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_chan = '0, cfg_reg = '0;
  logic [31:0] cfg_wdata = '0;
  logic hblank = 1'b0, vblank = 1'b0, xfer_ready = 1'b1;
  logic xfer_valid, xfer_wide, cpu_stall;
  logic [31:0] xfer_src, xfer_dst;
  logic [1:0] xfer_chan;
  logic [NCH-1:0] irq, chan_en;

  blank_dma #(.NCH(NCH), .CNT_W(CWL), .CNT_W_LAST(CWH)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_reg(cfg_reg),
    .cfg_wdata(cfg_wdata), .hblank(hblank), .vblank(vblank), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_wide(xfer_wide),
    .xfer_chan(xfer_chan), .cpu_stall(cpu_stall), .irq(irq), .chan_en(chan_en));

  always #(TCLK/2) clk = ~clk;

  int checks = 0, fails = 0, cycles = 0, ready_mode = 0;
  string phase = "R1";
  logic [15:0] lfsr = 16'hACE1;

  // behavioural model state
  logic [9:0]  m_ctl [NCH];
  logic [31:0] m_sp [NCH], m_dp [NCH], m_sw [NCH], m_dw [NCH];
  int          m_cp [NCH], m_cw [NCH];
  bit          m_arm [NCH], m_irq [NCH];

  function automatic int cmax(int ch); return (ch == NCH-1) ? (1 << CWH) - 1 : (1 << CWL) - 1; endfunction
  function automatic int reld(int ch); return (m_cp[ch] == 0) ? cmax(ch) : m_cp[ch]; endfunction
  function automatic logic [31:0] mv(logic [31:0] a, logic [1:0] m, logic w);
    int d = w ? 4 : 2;
    if (m == 2'd1) return a - 32'(d);
    if (m == 2'd2) return a;
    return a + 32'(d);
  endfunction
  function automatic int msel();
    for (int c = 0; c < NCH; c++) if (m_arm[c] && m_ctl[c][9]) return c;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_ctl[c] = '0; m_sp[c] = '0; m_dp[c] = '0; m_sw[c] = '0; m_dw[c] = '0;
        m_cp[c] = 0; m_cw[c] = 0; m_arm[c] = 0; m_irq[c] = 0;
      end
    end else begin
      int s;
      s = msel();
      for (int c = 0; c < NCH; c++) begin
        bit hit, edge_w;
        logic [9:0] k;
        k = m_ctl[c];
        hit = cfg_we && cfg_chan == 2'(c);
        edge_w = hit && cfg_reg == 2'd3 && cfg_wdata[9] && !k[9];
        m_irq[c] = 0;
        if (hit && cfg_reg == 2'd0) m_sp[c] = cfg_wdata;
        if (hit && cfg_reg == 2'd1) m_dp[c] = cfg_wdata;
        if (hit && cfg_reg == 2'd2) m_cp[c] = int'(cfg_wdata) & cmax(c);
        if (edge_w) begin
          m_sw[c] = m_sp[c]; m_dw[c] = m_dp[c]; m_cw[c] = reld(c);
          m_arm[c] = (cfg_wdata[7:6] == 2'd0);
        end else if (s == c && xfer_ready) begin
          m_sw[c] = mv(m_sw[c], k[3:2], k[5]);
          m_dw[c] = mv(m_dw[c], k[1:0], k[5]);
          m_cw[c] = m_cw[c] - 1;
          if (m_cw[c] == 0) begin
            m_arm[c] = 0;
            if (!k[4]) begin m_ctl[c][9] = 1'b0; m_irq[c] = k[8]; end
          end
        end else if (!m_arm[c] && k[9] &&
                     ((hblank && k[7:6] == 2'd2) || (vblank && k[7:6] == 2'd1))) begin
          m_arm[c] = 1;
          if (k[4]) begin
            m_cw[c] = reld(c);
            if (k[1:0] == 2'd3) m_dw[c] = m_dp[c];
          end
        end
        if (hit && cfg_reg == 2'd3) m_ctl[c] = cfg_wdata[9:0];
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int s;
    s = msel();
    chk("valid", 32'(xfer_valid), 32'(s >= 0));
    chk("stall", 32'(cpu_stall), 32'(s >= 0 && m_ctl[(s < 0) ? 0 : s][7:6] == 2'd0));
    for (int c = 0; c < NCH; c++) begin
      chk("irq", 32'(irq[c]), 32'(m_irq[c]));
      chk("enable", 32'(chan_en[c]), 32'(m_ctl[c][9]));
    end
    if (s >= 0) begin
      chk("chan", 32'(xfer_chan), 32'(s));
      chk("src", xfer_src, m_sw[s]);
      chk("dst", xfer_dst, m_dw[s]);
      chk("wide", 32'(xfer_wide), 32'(m_ctl[s][5]));
    end
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    xfer_ready <= (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? lfsr[0] : 1'b0;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic wr(int ch, int r, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_chan = 2'(ch); cfg_reg = 2'(r); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask
  task automatic pulse(bit h);
    @(negedge clk);
    if (h) hblank = 1'b1; else vblank = 1'b1;
    @(negedge clk);
    hblank = 1'b0; vblank = 1'b0;
  endtask
  // ctrl: [9] en [8] irq [7:6] start [5] wide [4] rpt [3:2] src [1:0] dst
  function automatic logic [31:0] ctl(bit en, bit ie, int st, bit w, bit rp, int sm, int dm);
    return {22'd0, en, ie, 2'(st), w, rp, 2'(sm), 2'(dm)};
  endfunction
  task automatic prog(int ch, logic [31:0] s, logic [31:0] d, int n);
    wr(ch, 0, s); wr(ch, 1, d); wr(ch, 2, 32'(n));
  endtask

  initial begin
    phase = "R1";
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    phase = "R4/R6/R10";   // immediate, 32-bit, src up, dst down, irq
    prog(2, 32'h1000, 32'h2000, 3);
    wr(2, 3, ctl(1, 1, 0, 1, 0, 0, 1));
    cyc(8);

    phase = "R4/R11";      // decrement wrap under back-pressure
    ready_mode = 1;
    prog(3, 32'h4, 32'h80, 5);
    wr(3, 3, ctl(1, 1, 0, 0, 0, 1, 0));
    cyc(40);
    ready_mode = 0;

    phase = "R7/R8";       // hblank repeat with destination reload
    prog(0, 32'h300, 32'h500, 2);
    wr(0, 3, ctl(1, 1, 2, 1, 1, 0, 3));
    cyc(3);
    pulse(0);
    cyc(3);
    pulse(1);
    cyc(5);
    pulse(1);
    cyc(5);
    wr(0, 3, ctl(0, 0, 2, 1, 1, 0, 3));
    cyc(2);

    phase = "R3/R8";       // vblank non-repeat, fixed source, 16-bit
    prog(1, 32'h700, 32'h900, 2);
    wr(1, 3, ctl(1, 1, 1, 0, 0, 2, 0));
    pulse(1);
    cyc(3);
    pulse(0);
    cyc(5);

    phase = "R9";          // two immediate channels armed together
    ready_mode = 2;
    cyc(1);
    prog(3, 32'hA000, 32'hB000, 3);
    prog(0, 32'hC000, 32'hD000, 3);
    wr(3, 3, ctl(1, 0, 0, 1, 0, 0, 0));
    wr(0, 3, ctl(1, 0, 0, 1, 0, 0, 0));
    cyc(3);
    ready_mode = 0;
    cyc(10);

    phase = "R5";          // zero count means maximum; masked high bits
    prog(1, 32'h0, 32'h10000, 0);
    wr(1, 3, ctl(1, 1, 0, 0, 0, 0, 0));
    cyc(70);
    prog(3, 32'h0, 32'h20000, 0);
    wr(3, 3, ctl(1, 1, 0, 1, 0, 0, 0));
    cyc(262);
    prog(0, 32'h40, 32'h50, 32'h1C5);
    wr(0, 3, ctl(1, 1, 0, 0, 0, 0, 0));
    cyc(10);

    phase = "R3";          // special timing never arms
    prog(2, 32'h11, 32'h22, 2);
    wr(2, 3, ctl(1, 1, 3, 0, 0, 0, 0));
    pulse(1); pulse(0);
    cyc(4);
    wr(2, 3, ctl(0, 0, 3, 0, 0, 0, 0));

    phase = "R2";          // writes while active reach working regs only on the next edge
    ready_mode = 2;
    prog(1, 32'h100, 32'h200, 4);
    wr(1, 3, ctl(1, 1, 0, 0, 0, 0, 0));
    wr(1, 0, 32'h9990);
    wr(1, 2, 32'd2);
    cyc(2);
    ready_mode = 0;
    cyc(8);
    wr(1, 3, ctl(1, 1, 0, 0, 0, 0, 0));
    cyc(6);

    phase = "R4";          // source mode 3 behaves as increment
    prog(2, 32'hFFFFFFFC, 32'h40, 3);
    wr(2, 3, ctl(1, 0, 0, 1, 0, 3, 2));
    cyc(8);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule